// File: doc/BRIEF.md
# Card Host Interrupt and DMA Request Router

This block gathers the thirteen event sources of a memory-card host controller into one pending-request register, filters them through a software-written mask, and produces a single level interrupt towards the processor plus two level request lines towards a DMA engine, one for the receive FIFO and one for the transmit FIFO. Event pulses from the command and data logic set pending bits. Bus writes to the pending register clear bits with write-one-to-clear. Accesses to the FIFO data ports clear the matching FIFO-service bit. Clock start and stop pulses clear and set the clock-off bit.

A routing state machine follows the controller's DMA-enable control bit, supplied on `dma_mode`. It has two states. In `ROUTE_CPU` the FIFO-service bits behave like every other source and both DMA lines stay low. In `ROUTE_DMA` the two FIFO-service bits are withheld from the processor interrupt, whatever the mask holds, and drive the DMA lines directly. The transition `ROUTE_CPU -> ROUTE_DMA` is taken on any cycle with `dma_mode` high. The transition `ROUTE_DMA -> ROUTE_CPU` is taken on any cycle with `dma_mode` low. All three outputs are registered and are computed from the pending register, the mask register and the routing state.

Source bit positions (bit 0 upward): 0 data done, 1 programming done, 2 command end, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 transfer interrupt, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card suspend acknowledge. Bus register addresses: 0 mask, 1 pending, 2 receive data port, 3 transmit data port.

Top module: `irq_dma_router`

## Requirements
- R1: After reset the pending and mask registers read as zero, the routing state is `ROUTE_CPU`, and `cpu_irq`, `dma_rx_req` and `dma_tx_req` are low.
- R2: A bus write to address 0 loads the mask from `bus_wdata[12:0]` on that clock edge; a read of address 0 returns the mask in bits 12:0 and zero in bits 15:13.
- R3: `cpu_irq` is high exactly when, in the previous cycle's state, some pending bit was set whose mask bit was 0 (mask bit 1 blocks that source), and the FIFO exclusion of R4 did not remove it; it updates one clock edge after the pending, mask or routing state changes.
- R4: In `ROUTE_DMA`, pending bits 5 and 6 never contribute to `cpu_irq`, even with their mask bits at 0.
- R5: The routing state takes the value of `dma_mode` at each clock edge; in `ROUTE_DMA` `dma_rx_req` equals pending bit 5 and `dma_tx_req` equals pending bit 6 one edge later, and in `ROUTE_CPU` both DMA lines are low.
- R6: A 1 on `evt_set[i]` sets pending bit i at the next edge; when a set and any clear hit the same bit in the same cycle, the set wins.
- R7: A bus write to address 1 clears every pending bit whose position holds a 1 in `bus_wdata[12:0]` and leaves the others; a read of address 1 returns the pending bits in 12:0 and zero above.
- R8: A bus read of address 2 clears pending bit 5; a bus write to address 3 clears pending bit 6; reads of addresses 2 and 3 return zero.
- R9: A `clk_stop` pulse sets pending bit 4, a `clk_start` pulse clears it, and when both arrive together the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | Register address: 0 mask, 1 pending, 2 receive port, 3 transmit port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| evt_set | input | 13 | One-cycle event pulses that set pending bits |
| clk_start | input | 1 | Card clock start pulse |
| clk_stop | input | 1 | Card clock stop pulse |
| dma_mode | input | 1 | DMA-enable control bit from the command register |
| cpu_irq | output | 1 | Level interrupt to the processor |
| dma_rx_req | output | 1 | Receive DMA request level |
| dma_tx_req | output | 1 | Transmit DMA request level |

## Verification
The hardest situation to reach is the collision of a set and a clear on the same pending bit in the same cycle, because the event logic and the bus must strike together: the stimulus issues a write-one-to-clear and an event pulse for bit 2 on one edge, a receive-port read together with a receive-service event on another, and both clock pulses at once. The second subtle point is the mode switch with FIFO-service bits already pending and unmasked, where `cpu_irq` must drop and the DMA lines rise on the same edge; the stimulus parks bits 5 and 6 pending, then toggles `dma_mode` in both directions while a scoreboard tracks every output cycle by cycle.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    // Source positions whose behaviour is fixed by the routing rules
    localparam int unsigned BIT_CLKOFF = 4;
    localparam int unsigned BIT_RXSVC  = 5;
    localparam int unsigned BIT_TXSVC  = 6;

    typedef enum logic [1:0] {
        A_MASK   = 2'd0,
        A_PEND   = 2'd1,
        A_RXPORT = 2'd2,
        A_TXPORT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ROUTE_CPU = 1'b0,
        ROUTE_DMA = 1'b1
    } route_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int unsigned SRC_N = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_vec,
    input  logic [SRC_N-1:0] clr_vec,
    output logic [SRC_N-1:0] pend_q
);

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                pend_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned SRC_N = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SRC_N-1:0] value,
    output logic [SRC_N-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= value;
        end
    end

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_rt_pkg::*;
#(
    parameter int unsigned SRC_N = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_mode,
    input  logic [SRC_N-1:0] pend_q,
    input  logic [SRC_N-1:0] mask_q,
    output logic             in_dma,
    output logic             cpu_irq,
    output logic             dma_rx_req,
    output logic             dma_tx_req
);

    localparam logic [SRC_N-1:0] FIFO_BITS =
        (SRC_N'(1) << BIT_RXSVC) | (SRC_N'(1) << BIT_TXSVC);

    route_e           state_q;
    route_e           state_d;
    logic [SRC_N-1:0] eff_mask;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROUTE_CPU: if (dma_mode)  state_d = ROUTE_DMA;
            ROUTE_DMA: if (!dma_mode) state_d = ROUTE_CPU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ROUTE_CPU;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        eff_mask = mask_q;
        if (state_q == ROUTE_DMA) begin
            eff_mask = mask_q | FIFO_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_irq    <= 1'b0;
            dma_rx_req <= 1'b0;
            dma_tx_req <= 1'b0;
        end else begin
            cpu_irq <= |(pend_q & ~eff_mask);
            unique case (state_q)
                ROUTE_CPU: begin
                    dma_rx_req <= 1'b0;
                    dma_tx_req <= 1'b0;
                end
                ROUTE_DMA: begin
                    dma_rx_req <= pend_q[BIT_RXSVC];
                    dma_tx_req <= pend_q[BIT_TXSVC];
                end
            endcase
        end
    end

    assign in_dma = (state_q == ROUTE_DMA);

endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
    import irq_rt_pkg::*;
#(
    parameter int unsigned SRC_N  = 13,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  evt_set,
    input  logic              clk_start,
    input  logic              clk_stop,
    input  logic              dma_mode,
    output logic              cpu_irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);

    localparam logic [SRC_N-1:0] ONE = SRC_N'(1);

    reg_addr_e        addr;
    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] mask_q;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic             mask_load;
    logic             route_dma;
    logic             wdata_hi_unused;

    assign addr            = reg_addr_e'(bus_addr);
    assign wdata_hi_unused = ^bus_wdata[DATA_W-1:SRC_N];
    assign mask_load       = bus_wr && (addr == A_MASK);

    always_comb begin
        set_vec = evt_set;
        if (clk_stop) begin
            set_vec = set_vec | (ONE << BIT_CLKOFF);
        end
    end

    always_comb begin
        clr_vec = '0;
        if (bus_wr && addr == A_PEND) begin
            clr_vec = bus_wdata[SRC_N-1:0];
        end
        if (bus_rd && addr == A_RXPORT) begin
            clr_vec = clr_vec | (ONE << BIT_RXSVC);
        end
        if (bus_wr && addr == A_TXPORT) begin
            clr_vec = clr_vec | (ONE << BIT_TXSVC);
        end
        if (clk_start) begin
            clr_vec = clr_vec | (ONE << BIT_CLKOFF);
        end
    end

    always_comb begin
        unique case (addr)
            A_MASK:   bus_rdata = DATA_W'(mask_q);
            A_PEND:   bus_rdata = DATA_W'(pend_q);
            A_RXPORT: bus_rdata = '0;
            A_TXPORT: bus_rdata = '0;
        endcase
    end

    irq_pend_reg #(.SRC_N(SRC_N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    irq_mask_reg #(.SRC_N(SRC_N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mask_load),
        .value  (bus_wdata[SRC_N-1:0]),
        .mask_q (mask_q)
    );

    irq_route_fsm #(.SRC_N(SRC_N)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_mode   (dma_mode),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .in_dma     (route_dma),
        .cpu_irq    (cpu_irq),
        .dma_rx_req (dma_rx_req),
        .dma_tx_req (dma_tx_req)
    );

endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
    import irq_rt_pkg::*;
#(
    parameter int unsigned SRC_N  = 13,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  evt_set,
    input logic              clk_start,
    input logic              clk_stop,
    input logic              dma_mode,
    input logic [SRC_N-1:0]  pend_q,
    input logic [SRC_N-1:0]  mask_q,
    input logic              route_dma,
    input logic              cpu_irq,
    input logic              dma_rx_req,
    input logic              dma_tx_req
);

    localparam logic [SRC_N-1:0] FIFO_BITS =
        (SRC_N'(1) << BIT_RXSVC) | (SRC_N'(1) << BIT_TXSVC);

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK) |=> mask_q == $past(bus_wdata[SRC_N-1:0]));

    assert_cpu_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(route_dma) |-> cpu_irq == |($past(pend_q) & ~$past(mask_q)));

    assert_fifo_withheld_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(route_dma) |-> cpu_irq == |($past(pend_q) & ~($past(mask_q) | FIFO_BITS)));

    assert_route_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        route_dma == $past(dma_mode));

    assert_dma_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(route_dma) |-> (dma_rx_req == $past(pend_q[BIT_RXSVC]))
                          && (dma_tx_req == $past(pend_q[BIT_TXSVC])));

    assert_dma_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(route_dma) |-> !dma_rx_req && !dma_tx_req);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> (pend_q & $past(evt_set)) == $past(evt_set));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PEND && evt_set == '0 && !clk_stop)
        |=> (pend_q & $past(bus_wdata[SRC_N-1:0])) == '0);

    assert_rx_port_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXPORT && !evt_set[BIT_RXSVC]) |=> !pend_q[BIT_RXSVC]);

    assert_tx_port_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXPORT && !evt_set[BIT_TXSVC]) |=> !pend_q[BIT_TXSVC]);

    assert_clk_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> pend_q[BIT_CLKOFF]);

    assert_clk_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_start && !clk_stop && !evt_set[BIT_CLKOFF]) |=> !pend_q[BIT_CLKOFF]);

endmodule

bind irq_dma_router irq_dma_router_chk #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_set    (evt_set),
    .clk_start  (clk_start),
    .clk_stop   (clk_stop),
    .dma_mode   (dma_mode),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .route_dma  (route_dma),
    .cpu_irq    (cpu_irq),
    .dma_rx_req (dma_rx_req),
    .dma_tx_req (dma_tx_req)
);

// File: tb/sim_irq_dma_router.sv
`timescale 1ns/1ps
module sim_irq_dma_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [12:0] evt_set = '0;
    logic        clk_start = 1'b0;
    logic        clk_stop = 1'b0;
    logic        dma_mode = 1'b0;
    logic        cpu_irq;
    logic        dma_rx_req;
    logic        dma_tx_req;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;

    logic [12:0] m_pend = '0;
    logic [12:0] m_mask = '0;
    logic        m_route = 1'b0;
    logic [2:0]  exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq_dma_router u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .clk_start(clk_start), .clk_stop(clk_stop),
        .dma_mode(dma_mode), .cpu_irq(cpu_irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] model_out();
        logic [12:0] eff;
        eff = m_mask | (m_route ? 13'h0060 : 13'h0000);
        return {|(m_pend & ~eff), m_route & m_pend[5], m_route & m_pend[6]};
    endfunction

    // monitor: outputs after an edge reflect the state pushed one step earlier
    always @(negedge clk) begin
        if (mon_on && exp_q.size() >= 2) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " outputs"}, {13'd0, cpu_irq, dma_rx_req, dma_tx_req}, {13'd0, e});
        end
    end

    // driver: one clock per call, starting and ending at a falling edge
    task automatic step(input string tag, input bit wr, input bit rd,
                        input logic [1:0] addr, input logic [15:0] wd,
                        input logic [12:0] set, input bit st, input bit sp);
        logic [12:0] clr;
        logic [12:0] setv;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        evt_set = set; clk_start = st; clk_stop = sp;
        @(posedge clk);
        clr = '0;
        if (wr && addr == 2'd1) clr = wd[12:0];
        if (rd && addr == 2'd2) clr[5] = 1'b1;
        if (wr && addr == 2'd3) clr[6] = 1'b1;
        if (st) clr[4] = 1'b1;
        setv = set;
        if (sp) setv[4] = 1'b1;
        if (wr && addr == 2'd0) m_mask = wd[12:0];
        m_pend = (m_pend & ~clr) | setv;
        m_route = dma_mode;
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; evt_set = '0; clk_start = 1'b0; clk_stop = 1'b0;
        bus_addr = 2'd1; #1;
        check({tag, " pending readback R7"}, bus_rdata, {3'b000, m_pend});
        bus_addr = 2'd0; #1;
        check({tag, " mask readback R2"}, bus_rdata, {3'b000, m_mask});
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        bus_addr = 2'd1; #1;
        check("R1 pending", bus_rdata, 16'h0000);
        bus_addr = 2'd0; #1;
        check("R1 mask", bus_rdata, 16'h0000);
        check("R1 outputs", {13'd0, cpu_irq, dma_rx_req, dma_tx_req}, 16'h0000);
        bus_addr = 2'd2; #1;
        check("R8 rx port reads zero", bus_rdata, 16'h0000);
        bus_addr = 2'd3; #1;
        check("R8 tx port reads zero", bus_rdata, 16'h0000);
        bus_addr = 2'd0;
        rst_n = 1'b1;
        exp_q.push_back(3'b000);
        tag_q.push_back("R1");
        mon_on = 1'b1;

        // R2: only the low 13 bits of a mask write are kept
        step("R2", 1'b1, 1'b0, 2'd0, 16'hFFFF, 13'h0, 1'b0, 1'b0);
        step("R2", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0001, 1'b0, 1'b0);
        idle("R3");
        step("R2", 1'b1, 1'b0, 2'd0, 16'hE000, 13'h0, 1'b0, 1'b0);
        idle("R3");

        // R6: event pulses set pending bits
        step("R6", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0A00, 1'b0, 1'b0);
        idle("R6");
        // R7: write-one-to-clear on the pending register
        step("R7", 1'b1, 1'b0, 2'd1, 16'h0201, 13'h0, 1'b0, 1'b0);
        idle("R7");
        // R3: masking the last source drops the interrupt
        step("R3", 1'b1, 1'b0, 2'd0, 16'h0800, 13'h0, 1'b0, 1'b0);
        idle("R3");
        step("R3", 1'b1, 1'b0, 2'd0, 16'h0000, 13'h0, 1'b0, 1'b0);
        idle("R3");
        // R6: set beats a same-cycle clear
        step("R6", 1'b1, 1'b0, 2'd1, 16'h1FFF, 13'h0004, 1'b0, 1'b0);
        idle("R6");
        step("R7", 1'b1, 1'b0, 2'd1, 16'hFFFF, 13'h0, 1'b0, 1'b0);
        idle("R7");

        // R9: clock pulses drive the clock-off bit
        step("R9", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b0, 1'b1);
        idle("R9");
        step("R9", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b1, 1'b0);
        idle("R9");
        step("R9", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b1, 1'b1);
        idle("R9");
        step("R9", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b1, 1'b0);
        idle("R9");

        // R5 / R4: FIFO service bits in both routing states
        step("R5", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0060, 1'b0, 1'b0);
        idle("R5");
        dma_mode = 1'b1;
        idle("R4");
        idle("R4");
        idle("R5");
        step("R4", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0100, 1'b0, 1'b0);
        idle("R4");
        step("R7", 1'b1, 1'b0, 2'd1, 16'h0100, 13'h0, 1'b0, 1'b0);
        idle("R4");
        // R8: port accesses clear the service bits
        step("R8", 1'b0, 1'b1, 2'd2, 16'h0, 13'h0, 1'b0, 1'b0);
        idle("R8");
        step("R8", 1'b1, 1'b0, 2'd3, 16'h0, 13'h0, 1'b0, 1'b0);
        idle("R8");
        step("R8", 1'b0, 1'b1, 2'd2, 16'h0, 13'h0020, 1'b0, 1'b0);
        idle("R8");
        step("R5", 1'b0, 1'b0, 2'd0, 16'h0, 13'h0040, 1'b0, 1'b0);
        idle("R5");
        dma_mode = 1'b0;
        idle("R5");
        idle("R5");
        step("R3", 1'b1, 1'b0, 2'd0, 16'h0040, 13'h0, 1'b0, 1'b0);
        idle("R3");
        dma_mode = 1'b1;
        idle("R5");
        idle("R5");
        dma_mode = 1'b0;
        step("R8", 1'b1, 1'b0, 2'd3, 16'h0, 13'h0, 1'b0, 1'b0);
        step("R8", 1'b0, 1'b1, 2'd2, 16'h0, 13'h0, 1'b0, 1'b0);
        idle("R5");
        idle("R5");

        summary();
        $finish;
    end

endmodule